// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked requester on chip read and write an external 32K x 8 asynchronous static RAM that has no output-enable pin and is selected by a pair of chip enables, one active low and one active high. The requester offers one transfer at a time over a valid/ready handshake: a 15-bit address, a write flag and 8-bit write data. Reads return their byte with a one-cycle valid pulse.

On the RAM side the controller drives the address, both chip enables, the active-low write strobe and a split data bus (output value, output enable, input value) meant for a tri-state pad. The RAM drives its data pins whenever it is selected with the write strobe high, so the controller holds the write strobe low for a worst-case release time before it drives, and lets go of the bus on the same edge the strobe returns high. Every timing interval is a count of clock cycles. These counts are derived from the clock period and from a speed-grade parameter that picks the 70 ns or the 85 ns set of minima.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted the active-low chip enable and the write strobe are high, the active-high chip enable is low, the data bus output enable is low, and no read-valid pulse is given.
- R2: A read holds the active-low chip enable low, the active-high chip enable high and the write strobe high from the accept edge until data is captured. The byte present on the data input 9 clock edges after the accept edge (85 ns grade, 10 ns clock) is returned with a read-valid pulse that is exactly one cycle wide.
- R3: The RAM address changes only on an edge where the write strobe is high both before and after that edge.
- R4: The controller drives the data bus only after the write strobe has been low for more than 3 cycles (30 ns release time). It drops the output enable on the same edge on which the write strobe rises.
- R5: A write presents the address with the strobe high for one cycle and then holds the write strobe low for exactly 7 cycles. The data is driven for at least 4 cycles before the strobe rises, and the RAM stores the byte that was driven at that moment.
- R6: After an accept, the next request is accepted no earlier than 9 cycles later (both reads and writes, 85 ns grade). When the next request is already waiting, it is accepted exactly 9 cycles later, with no idle cycle added.
- R7: The write strobe is low only while both chip enables are active. Ready is low for the whole of the write strobe's low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the read byte |
| rd_data | output | 8 | Read byte |
| sram_addr | output | 15 | RAM address bus |
| sram_ce1_n | output | 1 | RAM chip enable, active low |
| sram_ce2 | output | 1 | RAM chip enable, active high |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_dq_out | output | 8 | Value for the RAM data pad |
| sram_dq_oe | output | 1 | Output enable for the RAM data pad |
| sram_dq_in | input | 8 | Value read from the RAM data pad |

## Verification
The bench's RAM model drives its data pins while selected with the strobe high, and for three cycles after the strobe falls. Its data is valid only after the full access time at a stable address. A controller that drives one cycle too soon therefore shows a bus fight, and one that captures one edge too early returns the model's filler byte instead of the stored value. Writes are committed by the model only at the strobe's rising edge, using whatever the controller drives at that point, so a bus released early or a short pulse loses the byte. Back-to-back traffic, including read after write to the same address and rewrites of one address, checks that the cycle-time gap is exact: neither an extra idle cycle nor an early accept that would move the address under a low strobe.

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl #(
  parameter int AW         = 15,
  parameter int DW         = 8,
  parameter int CLK_NS     = 10,
  parameter bit FAST_GRADE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  localparam int T_RC  = FAST_GRADE ? 70 : 85;
  localparam int T_AA  = FAST_GRADE ? 70 : 85;
  localparam int T_WC  = FAST_GRADE ? 70 : 85;
  localparam int T_CW  = FAST_GRADE ? 50 : 70;
  localparam int T_WP  = FAST_GRADE ? 55 : 65;
  localparam int T_DW  = FAST_GRADE ? 30 : 35;
  localparam int T_WHZ = 30;

  localparam int N_RC  = (T_RC  + CLK_NS - 1) / CLK_NS;
  localparam int N_AA  = (T_AA  + CLK_NS - 1) / CLK_NS;
  localparam int N_WC  = (T_WC  + CLK_NS - 1) / CLK_NS;
  localparam int N_CW  = (T_CW  + CLK_NS - 1) / CLK_NS;
  localparam int N_WP  = (T_WP  + CLK_NS - 1) / CLK_NS;
  localparam int N_DW  = (T_DW  + CLK_NS - 1) / CLK_NS;

  localparam int HIZ_CY = (T_WHZ + CLK_NS - 1) / CLK_NS;
  localparam int WP_A   = (N_WP > N_CW - 1) ? N_WP : N_CW - 1;
  localparam int WP_CY  = (WP_A > HIZ_CY + N_DW) ? WP_A : HIZ_CY + N_DW;
  localparam int ACC_CY = N_AA;
  localparam int RC_CY  = (N_RC > ACC_CY) ? N_RC : ACC_CY;
  localparam int WC_CY  = (N_WC > WP_CY + 2) ? N_WC : WP_CY + 2;
  localparam int TOP_CY = (RC_CY > WC_CY) ? RC_CY : WC_CY;
  localparam int CW     = $clog2(TOP_CY + 2);

  localparam logic [CW-1:0] C_ACC  = CW'(ACC_CY);
  localparam logic [CW-1:0] C_RC   = CW'(RC_CY);
  localparam logic [CW-1:0] C_WC   = CW'(WC_CY);
  localparam logic [CW-1:0] C_WEF  = CW'(1);
  localparam logic [CW-1:0] C_DRV  = CW'(1 + HIZ_CY);
  localparam logic [CW-1:0] C_WER  = CW'(1 + WP_CY);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          last;
  logic          take;

  assign last      = (st == S_RD && cnt == C_RC) || (st == S_WR && cnt == C_WC);
  assign req_ready = (st == S_IDLE) || last;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      sram_addr   <= '0;
      sram_ce1_n  <= 1'b1;
      sram_ce2    <= 1'b0;
      sram_we_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      sram_dq_out <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (st != S_IDLE) cnt <= cnt + 1'b1;

      if (st == S_RD && cnt == C_ACC) begin
        rd_data  <= sram_dq_in;
        rd_valid <= 1'b1;
      end

      if (st == S_WR && cnt == C_WEF) sram_we_n  <= 1'b0;
      if (st == S_WR && cnt == C_DRV) sram_dq_oe <= 1'b1;
      if (st == S_WR && cnt == C_WER) begin
        sram_we_n  <= 1'b1;
        sram_dq_oe <= 1'b0;
      end

      if (take) begin
        st          <= req_write ? S_WR : S_RD;
        cnt         <= CW'(1);
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
        sram_ce1_n  <= 1'b0;
        sram_ce2    <= 1'b1;
      end else if (last) begin
        st         <= S_IDLE;
        cnt        <= '0;
        sram_ce1_n <= 1'b1;
        sram_ce2   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce1_n,
  input logic          sram_ce2,
  input logic          sram_we_n,
  input logic          sram_dq_oe
);

  AST_ADDR_MOVES_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n))); // R3

  AST_DRIVE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n && !$past(sram_we_n))); // R4

  AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> !sram_dq_oe); // R4

  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R2

  AST_WE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce1_n && sram_ce2)); // R7

  AST_NO_READY_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !req_ready); // R7

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sram_port_ctrl_test.sv
module sram_port_ctrl_test;
  localparam int HIZ = 3, WP = 7, ACC = 9, CYC = 9, DS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] sram_addr;
  logic        sram_ce1_n, sram_ce2, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_out;
  logic [7:0]  ram_out = 8'h5A;

  int checks = 0, fails = 0;

  sram_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(ram_out));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  logic [7:0] ram_mem [int];
  logic [7:0] exp_mem [int];
  logic [7:0] exp_q [$];
  int         exp_cyc [$];

  logic        p_valid = 0, p_ready = 0, p_write = 0, p_we = 1, p_oe = 0, p_sel = 0;
  logic [14:0] p_addr = '0, p_saddr = '0;
  logic [7:0]  p_wdata = '0, p_dq = '0;
  int cyc = 0, last_acc = -1, need = 0, lowcnt = 0, drvcnt = 0, stable = 0;
  bit held = 0, in_read = 0;

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic sel;
      cyc++;
      sel = !sram_ce1_n && sram_ce2;
      if (p_valid && p_ready) begin
        if (last_acc >= 0) begin
          chk(cyc - last_acc >= need, "R6 min gap", cyc - last_acc, need);
          if (held) chk(cyc - last_acc == need, "R6 exact gap", cyc - last_acc, need);
        end
        last_acc = cyc; need = CYC; held = 1;
        if (p_write) exp_mem[int'(p_addr)] = p_wdata;
        else begin
          exp_q.push_back(exp_mem.exists(int'(p_addr)) ? exp_mem[int'(p_addr)] : 8'h00);
          exp_cyc.push_back(cyc);
          in_read = 1;
        end
      end else if (!req_valid) held = 0;

      if (in_read) chk(sel && sram_we_n, "R2 read controls", {sram_ce1_n, sram_ce2, sram_we_n}, 3'b011);
      if (rd_valid) begin
        in_read = 0;
        if (exp_q.size() == 0) chk(0, "R2 spurious read valid", 1, 0);
        else begin
          logic [7:0] e;
          int c;
          e = exp_q.pop_front();
          c = exp_cyc.pop_front();
          chk(rd_data == e, "R2 read data", rd_data, e);
          chk(cyc - c == ACC, "R2 read latency", cyc - c, ACC);
        end
      end

      if (sram_addr != p_saddr) chk(sram_we_n && p_we, "R3 addr move with strobe", {p_we, sram_we_n}, 2'b11);
      if (!sram_we_n) chk(sel, "R7 strobe unselected", sel, 1);
      if (!sram_we_n) chk(!req_ready, "R7 ready in pulse", req_ready, 0);

      if (!p_we && sram_we_n) begin
        if (p_sel) ram_mem[int'(p_saddr)] = p_oe ? p_dq : 8'hEE;
        chk(lowcnt == WP, "R5 pulse width", lowcnt, WP);
        chk(p_oe && drvcnt >= DS, "R5 data setup", drvcnt, DS);
        chk(!sram_dq_oe, "R4 release on rise", sram_dq_oe, 0);
      end
      lowcnt = sram_we_n ? 0 : lowcnt + 1;
      drvcnt = sram_dq_oe ? drvcnt + 1 : 0;
      if (sram_dq_oe) chk(!sram_we_n && lowcnt > HIZ, "R4 bus fight", lowcnt, HIZ + 1);

      if (sel && sram_we_n && p_sel && p_we && sram_addr == p_saddr) stable++;
      else stable = 0;
      if (sel && sram_we_n && stable >= ACC - 1)
        ram_out = ram_mem.exists(int'(sram_addr)) ? ram_mem[int'(sram_addr)] : 8'h00;
      else ram_out = 8'h5A;
    end
    p_valid = req_valid; p_ready = req_ready; p_write = req_write;
    p_addr = req_addr; p_wdata = req_wdata; p_we = sram_we_n; p_oe = sram_dq_oe;
    p_dq = sram_dq_out; p_saddr = sram_addr; p_sel = !sram_ce1_n && sram_ce2;
  end

  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sram_ce1_n == 1, "R1 ce1_n", sram_ce1_n, 1);
    chk(sram_ce2 == 0, "R1 ce2", sram_ce2, 0);
    chk(sram_we_n == 1, "R1 we_n", sram_we_n, 1);
    chk(sram_dq_oe == 0, "R1 dq_oe", sram_dq_oe, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    issue(1, 15'h0000, 8'h00);
    issue(1, 15'h7FFF, 8'hFF);
    issue(1, 15'h1234, 8'hA5);
    issue(1, 15'h0555, 8'h3C);
    issue(0, 15'h1234, 8'h00);
    issue(0, 15'h7FFF, 8'h00);
    issue(0, 15'h0000, 8'h00);
    issue(0, 15'h2AAA, 8'h00);
    repeat (5) @(negedge clk);
    issue(0, 15'h0555, 8'h00);
    repeat (12) @(negedge clk);
    issue(1, 15'h0042, 8'h11);
    issue(1, 15'h0042, 8'h96);
    issue(0, 15'h0042, 8'h00);
    issue(1, 15'h7FFF, 8'h01);
    issue(0, 15'h7FFF, 8'h00);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      issue(1, 15'(i * 1111), 8'(i * 37 + 5));
      if (i % 2 == 1) repeat (i) @(negedge clk);
    end
    for (int i = 0; i < 6; i++) issue(0, 15'(i * 1111), 8'h00);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 reads outstanding", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    #1500000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule